// File: doc/BRIEF.md
# Reference-Window Clock Frequency Meter

This block estimates the rate of a clock of unknown frequency by counting its rising edges over an interval whose length is set by a trusted reference clock. A free-running phase counter in the reference domain defines a repeating period of 2^WIN_BITS reference cycles. Within each period it raises a short clear pulse, then opens a counting window, closes it again, and finally issues a capture strobe.

The window level enters the measured domain through a small register chain and gates an edge counter there. The clear pulse zeroes that counter asynchronously before the window opens. After the window has closed and the count has settled, the capture strobe copies the count into a result register in the reference domain. Software or a supervisor can read that register at any time, and it changes only on capture edges.

The stored count, divided by the window length in reference cycles and multiplied by the reference frequency, gives the measured frequency. That conversion happens outside this block.

Top module: `clk_freq_meter`

## Requirements
- R1: While `ref_rst` is high at a reference edge, the phase counter and all three control outputs (`win_clear`, `win_open`, `win_latch`) go to 0 and `freq_count` goes to 0. This holds for a reset applied in the middle of a period as well.
- R2: Let k be the number of reference edges since reset was released, and p = k mod 2^WIN_BITS. `win_latch` is high only when p = 2^WIN_BITS-1. It is therefore a one-cycle pulse that repeats every 2^WIN_BITS reference cycles.
- R3: `win_clear` is high exactly when p is 1 or 2, a two-cycle pulse at the start of each period.
- R4: `win_open` is high exactly when 5 <= p <= 2^WIN_BITS-5, a window of 2^WIN_BITS-9 reference cycles.
- R5: At most one of `win_clear`, `win_open` and `win_latch` is high in any reference cycle. Clearing and capture therefore never overlap the counting interval.
- R6: The measured-domain counter advances by one on a `meas_clk` edge only when the synchronised window level was high at that edge. Otherwise it holds, apart from the asynchronous clear to 0. With `meas_clk` stopped, the next capture reads 0.
- R7: `freq_count` changes only on the reference edge that follows a `win_latch` cycle. It holds its value between captures.
- R8: For a steady `meas_clk` of period Tm, each captured value is within 2 of (2^WIN_BITS-9)*Tref/Tm, provided that value is below 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Known reference clock that times the window |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| meas_clk | input | 1 | Clock whose frequency is measured |
| win_clear | output | 1 | Clear pulse for the measured-domain counter |
| win_open | output | 1 | Counting window level, reference domain |
| win_latch | output | 1 | Capture strobe, one reference cycle |
| freq_count | output | CNT_W | Last captured edge count |

## Verification
On every reference cycle, the checker compares the three control outputs against an independent phase counter. It also checks that they never overlap and that the result moves only after a capture strobe. On every measured-clock edge, it checks that the edge counter either steps by one under an open synchronised window, holds, or has just been cleared. Only the bench's scenarios can show that the captured numbers match the clock ratio for several measured periods, that a stopped measured clock yields 0, and that a reset in the middle of a period clears the result.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;

   // control bundle produced by the window sequencer
   typedef struct packed {
      logic clr;
      logic open;
      logic latch;
   } fm_ctl_t;

   // phase at which the counting window opens (decoded value)
   localparam int unsigned FM_OPEN_PHASE = 4;

   function automatic int unsigned fm_period(input int unsigned wbits);
      return 32'd1 << wbits;
   endfunction

   function automatic int unsigned fm_close_phase(input int unsigned wbits);
      return fm_period(wbits) - 5;
   endfunction

   function automatic int unsigned fm_latch_phase(input int unsigned wbits);
      return fm_period(wbits) - 2;
   endfunction

endpackage

// File: rtl/fm_window_seq.sv
`timescale 1ns/1ps
module fm_window_seq
   import fm_pkg::*;
#(
   parameter int WIN_BITS = 14,
   parameter int OPEN_AT  = 4,
   parameter int CLOSE_AT = (1 << 14) - 5,
   parameter int LATCH_AT = (1 << 14) - 2
) (
   input  logic    ref_clk,
   input  logic    ref_rst,
   output fm_ctl_t ctl_o
);

   localparam logic [WIN_BITS-1:0] PH_ZERO  = '0;
   localparam logic [WIN_BITS-1:0] PH_ONE   = WIN_BITS'(1);
   localparam logic [WIN_BITS-1:0] PH_OPEN  = WIN_BITS'(OPEN_AT);
   localparam logic [WIN_BITS-1:0] PH_CLOSE = WIN_BITS'(CLOSE_AT);
   localparam logic [WIN_BITS-1:0] PH_LATCH = WIN_BITS'(LATCH_AT);

   logic [WIN_BITS-1:0] phase_q;
   fm_ctl_t             ctl_q;
   logic                hit_clr;
   logic                hit_open;
   logic                hit_close;
   logic                hit_latch;

   always_comb begin
      hit_clr   = (phase_q == PH_ZERO) || (phase_q == PH_ONE);
      hit_open  = (phase_q == PH_OPEN);
      hit_close = (phase_q == PH_CLOSE);
      hit_latch = (phase_q == PH_LATCH);
   end

   always_ff @(posedge ref_clk) begin
      if (ref_rst) begin
         phase_q <= '0;
         ctl_q   <= '0;
      end else begin
         phase_q     <= phase_q + PH_ONE;
         ctl_q.clr   <= hit_clr;
         ctl_q.latch <= hit_latch;
         if (hit_open)
            ctl_q.open <= 1'b1;
         else if (hit_close)
            ctl_q.open <= 1'b0;
      end
   end

   assign ctl_o = ctl_q;

endmodule

// File: rtl/fm_enable_sync.sv
`timescale 1ns/1ps
module fm_enable_sync #(
   parameter int STAGES = 1
) (
   input  logic meas_clk,
   input  logic clr,
   input  logic win_in,
   output logic win_out
);

   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge meas_clk or posedge clr) begin
            if (clr)
               q <= 1'b0;
            else
               q <= win_in;
         end
         assign win_out = q;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge meas_clk or posedge clr) begin
            if (clr)
               sh <= '0;
            else
               sh <= {sh[STAGES-2:0], win_in};
         end
         assign win_out = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/fm_edge_counter.sv
`timescale 1ns/1ps
module fm_edge_counter #(
   parameter int CNT_W = 16
) (
   input  logic             meas_clk,
   input  logic             clr,
   input  logic             en,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge meas_clk or posedge clr) begin
      if (clr)
         cnt_q <= '0;
      else if (en)
         cnt_q <= cnt_q + STEP;
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/fm_result_reg.sv
`timescale 1ns/1ps
module fm_result_reg #(
   parameter int CNT_W = 16
) (
   input  logic             ref_clk,
   input  logic             ref_rst,
   input  logic             capture,
   input  logic [CNT_W-1:0] cnt_in,
   output logic [CNT_W-1:0] result
);

   logic [CNT_W-1:0] hold_q;

   always_ff @(posedge ref_clk) begin
      if (ref_rst)
         hold_q <= '0;
      else if (capture)
         hold_q <= cnt_in;
   end

   assign result = hold_q;

endmodule

// File: rtl/clk_freq_meter.sv
`timescale 1ns/1ps
module clk_freq_meter
   import fm_pkg::*;
#(
   parameter int WIN_BITS    = 14,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 1
) (
   input  logic             ref_clk,
   input  logic             ref_rst,
   input  logic             meas_clk,
   output logic             win_clear,
   output logic             win_open,
   output logic             win_latch,
   output logic [CNT_W-1:0] freq_count
);

   localparam int PERIOD   = int'(fm_period(WIN_BITS));
   localparam int OPEN_AT  = int'(FM_OPEN_PHASE);
   localparam int CLOSE_AT = int'(fm_close_phase(WIN_BITS));
   localparam int LATCH_AT = int'(fm_latch_phase(WIN_BITS));
   localparam int WIN_LEN  = CLOSE_AT - OPEN_AT;

   // elaboration-time parameter checks
   if (WIN_BITS < 4 || WIN_BITS > 24) begin : g_bad_win
      $error("clk_freq_meter: WIN_BITS must lie in 4..24");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("clk_freq_meter: CNT_W must lie in 2..32");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("clk_freq_meter: SYNC_STAGES must lie in 1..4");
   end
   if (WIN_LEN <= 0 || LATCH_AT >= PERIOD) begin : g_bad_order
      $error("clk_freq_meter: window points out of order");
   end

   fm_ctl_t          ctl;
   logic             win_sync;
   logic [CNT_W-1:0] meas_cnt;

   fm_window_seq #(
      .WIN_BITS (WIN_BITS),
      .OPEN_AT  (OPEN_AT),
      .CLOSE_AT (CLOSE_AT),
      .LATCH_AT (LATCH_AT)
   ) u_seq (
      .ref_clk (ref_clk),
      .ref_rst (ref_rst),
      .ctl_o   (ctl)
   );

   fm_enable_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .meas_clk (meas_clk),
      .clr      (ctl.clr),
      .win_in   (ctl.open),
      .win_out  (win_sync)
   );

   fm_edge_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .meas_clk (meas_clk),
      .clr      (ctl.clr),
      .en       (win_sync),
      .cnt      (meas_cnt)
   );

   fm_result_reg #(
      .CNT_W (CNT_W)
   ) u_res (
      .ref_clk (ref_clk),
      .ref_rst (ref_rst),
      .capture (ctl.latch),
      .cnt_in  (meas_cnt),
      .result  (freq_count)
   );

   assign win_clear = ctl.clr;
   assign win_open  = ctl.open;
   assign win_latch = ctl.latch;

endmodule

// File: rtl/fm_checker.sv
`timescale 1ns/1ps
module fm_checker #(
   parameter int WIN_BITS = 14,
   parameter int CNT_W    = 16
) (
   input logic             ref_clk,
   input logic             ref_rst,
   input logic             meas_clk,
   input logic             win_clear,
   input logic             win_open,
   input logic             win_latch,
   input logic [CNT_W-1:0] freq_count,
   input logic [CNT_W-1:0] meas_cnt,
   input logic             win_sync
);

   localparam logic [WIN_BITS-1:0] P_ONE   = WIN_BITS'(1);
   localparam logic [WIN_BITS-1:0] P_TWO   = WIN_BITS'(2);
   localparam logic [WIN_BITS-1:0] P_OPEN  = WIN_BITS'(5);
   localparam logic [WIN_BITS-1:0] P_SHUT  = WIN_BITS'((1 << WIN_BITS) - 5);
   localparam logic [WIN_BITS-1:0] P_LAST  = WIN_BITS'((1 << WIN_BITS) - 1);
   localparam logic [CNT_W-1:0]    C_ONE   = CNT_W'(1);

   // independent phase model: edges since reset release, modulo the period
   logic [WIN_BITS-1:0] ph;
   always_ff @(posedge ref_clk) begin
      if (ref_rst)
         ph <= '0;
      else
         ph <= ph + P_ONE;
   end

   AST_CLEAR_PHASE: assert property (@(posedge ref_clk) disable iff (ref_rst)
      win_clear |-> (ph == P_ONE || ph == P_TWO)); // R3
   AST_CLEAR_PRESENT: assert property (@(posedge ref_clk) disable iff (ref_rst)
      (ph == P_ONE || ph == P_TWO) |-> win_clear); // R3
   AST_OPEN_PHASE: assert property (@(posedge ref_clk) disable iff (ref_rst)
      win_open |-> (ph >= P_OPEN && ph <= P_SHUT)); // R4
   AST_OPEN_PRESENT: assert property (@(posedge ref_clk) disable iff (ref_rst)
      (ph >= P_OPEN && ph <= P_SHUT) |-> win_open); // R4
   AST_LATCH_PHASE: assert property (@(posedge ref_clk) disable iff (ref_rst)
      win_latch |-> (ph == P_LAST)); // R2
   AST_LATCH_PRESENT: assert property (@(posedge ref_clk) disable iff (ref_rst)
      (ph == P_LAST) |-> win_latch); // R2
   AST_CTL_EXCLUSIVE: assert property (@(posedge ref_clk) disable iff (ref_rst)
      $onehot0({win_clear, win_open, win_latch})); // R5
   AST_RESULT_HOLD: assert property (@(posedge ref_clk) disable iff (ref_rst)
      !win_latch |=> $stable(freq_count)); // R7
   AST_COUNT_IDLE: assert property (@(posedge meas_clk) disable iff (ref_rst || win_clear)
      !$past(win_sync) |-> ($stable(meas_cnt) || meas_cnt == '0)); // R6
   AST_COUNT_STEP: assert property (@(posedge meas_clk) disable iff (ref_rst || win_clear)
      $past(win_sync) |-> (meas_cnt == $past(meas_cnt) + C_ONE || meas_cnt == '0)); // R6

endmodule

bind clk_freq_meter fm_checker #(
   .WIN_BITS (WIN_BITS),
   .CNT_W    (CNT_W)
) u_chk (
   .ref_clk    (ref_clk),
   .ref_rst    (ref_rst),
   .meas_clk   (meas_clk),
   .win_clear  (win_clear),
   .win_open   (win_open),
   .win_latch  (win_latch),
   .freq_count (freq_count),
   .meas_cnt   (meas_cnt),
   .win_sync   (win_sync)
);

// File: tb/sim_clk_freq_meter.sv
`timescale 1ns/1ps
module sim_clk_freq_meter;

   localparam int WB   = 8;
   localparam int CW   = 16;
   localparam int NPER = 1 << WB;
   localparam int WLEN = NPER - 9;
   localparam real TREF = 10.0;

   logic          ref_clk  = 1'b0;
   logic          ref_rst  = 1'b1;
   logic          meas_clk = 1'b0;
   logic          win_clear;
   logic          win_open;
   logic          win_latch;
   logic [CW-1:0] freq_count;

   real mhalf = 7.0;
   bit  mrun  = 1'b1;
   int  checks = 0;
   int  errors = 0;
   int  k = 0;
   bit  done = 1'b0;

   clk_freq_meter #(.WIN_BITS(WB), .CNT_W(CW), .SYNC_STAGES(1)) u0 (
      .ref_clk    (ref_clk),
      .ref_rst    (ref_rst),
      .meas_clk   (meas_clk),
      .win_clear  (win_clear),
      .win_open   (win_open),
      .win_latch  (win_latch),
      .freq_count (freq_count)
   );

   always #5 ref_clk = ~ref_clk;

   always begin
      #(mhalf);
      if (mrun) meas_clk = ~meas_clk;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one reference edge, then settle at the following falling edge
   task automatic step();
      @(posedge ref_clk);
      k++;
      @(negedge ref_clk);
   endtask

   task automatic step_to(input int target);
      while (k < target) step();
   endtask

   task automatic do_reset();
      @(negedge ref_clk);
      ref_rst = 1'b1;
      repeat (3) @(negedge ref_clk);
      check(!win_clear && !win_open && !win_latch, "R1", "controls in reset",
            int'({win_clear, win_open, win_latch}), 0);
      check(freq_count == '0, "R1", "result in reset", int'(freq_count), 0);
      ref_rst = 1'b0;
      k = 0;
   endtask

   function automatic int expect_cnt(input real half);
      return int'((WLEN * TREF) / (2.0 * half));
   endfunction

   function automatic bit near(input int act, input int exp);
      return (act >= exp - 2) && (act <= exp + 2);
   endfunction

   // R2 R3 R4 R5: walk two full periods and compare each control
   task automatic t_phases();
      int bad_clr = 0, bad_open = 0, bad_latch = 0, latches = 0, overlap = 0;
      mrun = 1'b1;
      mhalf = 7.0;
      do_reset();
      for (int i = 1; i <= 2 * NPER; i++) begin
         int p;
         step();
         p = k % NPER;
         if (win_clear != (p == 1 || p == 2)) bad_clr++;
         if (win_open != (p >= 5 && p <= NPER - 5)) bad_open++;
         if (win_latch != (p == NPER - 1)) bad_latch++;
         if (win_latch) latches++;
         if (int'(win_clear) + int'(win_open) + int'(win_latch) > 1) overlap++;
      end
      check(bad_clr == 0, "R3", "clear phase mismatches", bad_clr, 0);
      check(bad_open == 0, "R4", "window phase mismatches", bad_open, 0);
      check(bad_latch == 0, "R2", "latch phase mismatches", bad_latch, 0);
      check(latches == 2, "R2", "latch pulses in two periods", latches, 2);
      check(overlap == 0, "R5", "overlapping controls", overlap, 0);
   endtask

   // R7 R8: measurement of a steady clock over two periods
   task automatic t_measure(input real half);
      int exp, first;
      mhalf = half;
      mrun = 1'b1;
      do_reset();
      exp = expect_cnt(half);
      step_to(NPER - 1);
      check(freq_count == '0, "R7", "result before first capture", int'(freq_count), 0);
      step_to(NPER);
      first = int'(freq_count);
      check(near(first, exp), "R8", "first capture", first, exp);
      step_to(2 * NPER - 1);
      check(int'(freq_count) == first, "R7", "result held between captures",
            int'(freq_count), first);
      step_to(2 * NPER);
      check(near(int'(freq_count), exp), "R8", "second capture", int'(freq_count), exp);
   endtask

   // R6: stopped measured clock reads zero after the next capture
   task automatic t_stopped();
      mhalf = 5.0;
      mrun = 1'b1;
      do_reset();
      step_to(NPER);
      check(near(int'(freq_count), expect_cnt(5.0)), "R8", "capture before stop",
            int'(freq_count), expect_cnt(5.0));
      mrun = 1'b0;
      step_to(2 * NPER);
      check(freq_count == '0, "R6", "capture with stopped clock", int'(freq_count), 0);
      mrun = 1'b1;
   endtask

   // R1: reset in the middle of a period clears the result and controls
   task automatic t_midreset();
      mhalf = 3.0;
      mrun = 1'b1;
      do_reset();
      step_to(NPER + 40);
      check(freq_count != '0, "R8", "nonzero before mid reset", int'(freq_count), 1);
      check(win_open, "R4", "window open mid period", int'(win_open), 1);
      ref_rst = 1'b1;
      @(posedge ref_clk);
      @(negedge ref_clk);
      check(!win_clear && !win_open && !win_latch, "R1", "controls after mid reset",
            int'({win_clear, win_open, win_latch}), 0);
      check(freq_count == '0, "R1", "result after mid reset", int'(freq_count), 0);
      ref_rst = 1'b0;
      k = 0;
   endtask

   initial begin
      t_phases();
      t_measure(7.0);
      t_measure(3.0);
      t_measure(23.0);
      t_measure(5.0);
      t_stopped();
      t_midreset();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge ref_clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule